// File: doc/BRIEF.md
# Dimension-Ordered Ring Router Node

This block is the routing stage that sits at one node of a fabric built from one-way rings laid out in one or two dimensions. A node has three packet sources: its own local injector, the incoming X ring and the incoming Y ring. It has three packet sinks: local delivery, the outgoing X ring and the outgoing Y ring. Every packet that arrives is steered to exactly one sink. The choice depends only on the node's own 5-bit identifier and the packet's destination identifier.

Routing is X first. A packet stays on the X ring until its X coordinate matches that of the destination node, then turns onto the Y ring, and is delivered once both coordinates match. The rings never carry traffic backwards. A reply therefore continues round the ring in the same direction as its request, and because it is also routed X first it may pass through different intermediate nodes. When every node shares one Y coordinate, only the X ring is ever used.

Each source feeds a small first-in first-out buffer. Each sink has one registered output slot. Traffic that is already on a ring takes precedence over traffic injected locally.

Top module: `ring_dor_router`

## Requirements
- R1: After synchronous reset, all three output valids are low and all three input readies are high.
- R2: A packet whose destination X coordinate (identifier bits 4:2) differs from the node's X coordinate leaves on the X ring output. This holds whether the packet was injected locally or arrived on the X ring.
- R3: A packet whose destination X coordinate equals the node's own but whose Y coordinate (identifier bits 1:0) differs leaves on the Y ring output.
- R4: A packet whose destination identifier equals the node identifier leaves on the local output.
- R5: A packet is laid out as source identifier (top 5 bits), destination identifier (next 5 bits), response flag (next bit) and payload (low bits). All fields leave unchanged. A packet accepted at clock edge k is valid at its output after edge k+1.
- R6: When several buffered packets want the same output in the same cycle, the Y ring input wins first, then the X ring input, and the local input last.
- R7: While an output is valid and its ready is low, the output stays valid and its data does not change.
- R8: An input buffer of DEPTH entries, together with an empty output slot, accepts DEPTH+1 packets toward a stalled output and then drops its ready. No packet is lost.
- R9: Packets from one input to one output leave in the order they were accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| self_id | input | 5 | This node's identifier (X in bits 4:2, Y in bits 1:0) |
| loc_in_valid | input | 1 | Local injection valid |
| loc_in_ready | output | 1 | Local injection ready |
| loc_in_data | input | PKT_W | Local injection packet |
| xin_valid | input | 1 | X ring input valid |
| xin_ready | output | 1 | X ring input ready |
| xin_data | input | PKT_W | X ring input packet |
| yin_valid | input | 1 | Y ring input valid |
| yin_ready | output | 1 | Y ring input ready |
| yin_data | input | PKT_W | Y ring input packet |
| loc_out_valid | output | 1 | Local delivery valid |
| loc_out_ready | input | 1 | Local delivery ready |
| loc_out_data | output | PKT_W | Local delivery packet |
| xout_valid | output | 1 | X ring output valid |
| xout_ready | input | 1 | X ring output ready |
| xout_data | output | PKT_W | X ring output packet |
| yout_valid | output | 1 | Y ring output valid |
| yout_ready | input | 1 | Y ring output ready |
| yout_data | output | PKT_W | Y ring output packet |

## Verification
A corrupted route decision shows up at the first output slot, two edges after the packet is accepted. The packet then appears on the wrong sink, and its destination coordinates contradict that sink. A broken buffer pointer or count has different symptoms: a repeated or missing payload in the drained sequence, or a wrong number of accepted packets before ready falls. A priority fault becomes visible one cycle after a collision, as the wrong packet in the contested slot. The vector table checks a full hop sequence for every node of a 2x2 grid and for a three-node X ring.

// File: rtl/ring_rt_pkg.sv
package ring_rt_pkg;
  localparam int ID_W  = 5;
  localparam int NPORT = 3;

  // input and output index; higher index wins arbitration
  typedef enum logic [1:0] {
    PORT_LOC = 2'd0,
    PORT_X   = 2'd1,
    PORT_Y   = 2'd2
  } port_e;

  function automatic port_e pick_port(input logic [ID_W-1:0] self,
                                      input logic [ID_W-1:0] dst);
    if (dst[4:2] != self[4:2])      return PORT_X;
    else if (dst[1:0] != self[1:0]) return PORT_Y;
    else                            return PORT_LOC;
  endfunction
endpackage

// File: rtl/ring_fifo.sv
module ring_fifo #(
  parameter int W     = 27,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  output logic         full,
  input  logic         rd_en,
  output logic         empty,
  output logic [W-1:0] rd_data
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [AW:0]   cnt;

  always_ff @(posedge clk) begin
    if (wr_en) mem[wp] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (wr_en) wp <= (wp == AW'(DEPTH-1)) ? '0 : wp + 1'b1;
      if (rd_en) rp <= (rp == AW'(DEPTH-1)) ? '0 : rp + 1'b1;
      case ({wr_en, rd_en})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  assign full    = (cnt == (AW+1)'(DEPTH));
  assign empty   = (cnt == '0);
  assign rd_data = mem[rp];

  // R8
  fifo_no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> !full);
  // R9
  fifo_no_underflow_chk: assert property (@(posedge clk) disable iff (rst)
    rd_en |-> !empty);
endmodule

// File: rtl/ring_prio_arb.sv
module ring_prio_arb #(
  parameter int N = 3
) (
  input  logic         en,
  input  logic [N-1:0] want,
  output logic [N-1:0] gnt
);
  always_comb begin
    gnt = '0;
    for (int i = 0; i < N; i++) begin
      if (want[i]) gnt = N'(1) << i;
    end
    if (!en) gnt = '0;
  end
endmodule

// File: rtl/ring_out_slot.sv
module ring_out_slot #(
  parameter int W = 27,
  parameter int N = 3
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [N-1:0]        gnt,
  input  logic [N-1:0][W-1:0] cand,
  input  logic                ready,
  output logic                can_load,
  output logic                valid,
  output logic [W-1:0]        data
);
  logic [W-1:0] sel;

  always_comb begin
    sel = '0;
    for (int i = 0; i < N; i++) begin
      if (gnt[i]) sel = cand[i];
    end
  end

  assign can_load = !valid || ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid <= 1'b0;
      data  <= '0;
    end else if (can_load) begin
      valid <= |gnt;
      if (|gnt) data <= sel;
    end
  end

  // R7
  slot_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (valid && !ready) |=> (valid && $stable(data)));
  // R6
  slot_one_grant_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(gnt));
endmodule

// File: rtl/ring_dor_router.sv
module ring_dor_router
  import ring_rt_pkg::*;
#(
  parameter int PAYLOAD_W = 16,
  parameter int DEPTH     = 4,
  localparam int PKT_W    = 2*ID_W + 1 + PAYLOAD_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [ID_W-1:0]  self_id,
  input  logic             loc_in_valid,
  output logic             loc_in_ready,
  input  logic [PKT_W-1:0] loc_in_data,
  input  logic             xin_valid,
  output logic             xin_ready,
  input  logic [PKT_W-1:0] xin_data,
  input  logic             yin_valid,
  output logic             yin_ready,
  input  logic [PKT_W-1:0] yin_data,
  output logic             loc_out_valid,
  input  logic             loc_out_ready,
  output logic [PKT_W-1:0] loc_out_data,
  output logic             xout_valid,
  input  logic             xout_ready,
  output logic [PKT_W-1:0] xout_data,
  output logic             yout_valid,
  input  logic             yout_ready,
  output logic [PKT_W-1:0] yout_data
);
  localparam int DST_LSB = PAYLOAD_W + 1;

  logic [NPORT-1:0]             in_v, in_r, push, pop, f_full, f_empty;
  logic [NPORT-1:0][PKT_W-1:0]  in_d, head_d, o_d;
  logic [NPORT-1:0]             o_v, o_r, can_load;
  port_e                        head_port [NPORT];
  logic [NPORT-1:0][NPORT-1:0]  want, gnt;   // [output][input]

  assign in_v = {yin_valid, xin_valid, loc_in_valid};
  assign in_d = {yin_data,  xin_data,  loc_in_data};
  assign o_r  = {yout_ready, xout_ready, loc_out_ready};
  assign {yin_ready, xin_ready, loc_in_ready}    = in_r;
  assign {yout_valid, xout_valid, loc_out_valid} = o_v;
  assign loc_out_data = o_d[PORT_LOC];
  assign xout_data    = o_d[PORT_X];
  assign yout_data    = o_d[PORT_Y];

  for (genvar i = 0; i < NPORT; i++) begin : g_in
    assign in_r[i] = !f_full[i];
    assign push[i] = in_v[i] && !f_full[i];
    ring_fifo #(.W(PKT_W), .DEPTH(DEPTH)) fifo_i (
      .clk(clk), .rst(rst),
      .wr_en(push[i]), .wr_data(in_d[i]), .full(f_full[i]),
      .rd_en(pop[i]), .empty(f_empty[i]), .rd_data(head_d[i])
    );
    assign head_port[i] = pick_port(self_id, head_d[i][DST_LSB +: ID_W]);
  end

  for (genvar o = 0; o < NPORT; o++) begin : g_out
    for (genvar i = 0; i < NPORT; i++) begin : g_want
      assign want[o][i] = !f_empty[i] && (head_port[i] == port_e'(o));
    end
    ring_prio_arb #(.N(NPORT)) arb_i (
      .en(can_load[o]), .want(want[o]), .gnt(gnt[o])
    );
    ring_out_slot #(.W(PKT_W), .N(NPORT)) slot_i (
      .clk(clk), .rst(rst), .gnt(gnt[o]), .cand(head_d),
      .ready(o_r[o]), .can_load(can_load[o]),
      .valid(o_v[o]), .data(o_d[o])
    );
  end

  always_comb begin
    pop = '0;
    for (int o = 0; o < NPORT; o++) pop |= gnt[o];
  end

  // R2
  xout_route_chk: assert property (@(posedge clk) disable iff (rst)
    xout_valid |-> (xout_data[DST_LSB+2 +: 3] != self_id[4:2]));
  // R3
  yout_route_chk: assert property (@(posedge clk) disable iff (rst)
    yout_valid |-> ((yout_data[DST_LSB+2 +: 3] == self_id[4:2]) &&
                    (yout_data[DST_LSB +: 2] != self_id[1:0])));
  // R4
  loc_route_chk: assert property (@(posedge clk) disable iff (rst)
    loc_out_valid |-> (loc_out_data[DST_LSB +: ID_W] == self_id));
  // R6
  ring_first_chk: assert property (@(posedge clk) disable iff (rst)
    (want[PORT_X][PORT_X] && want[PORT_X][PORT_LOC]) |-> !pop[PORT_LOC]);
endmodule

// File: tb/ring_dor_router_tb_top.sv
module ring_dor_router_tb_top;
  localparam int PW  = 16;
  localparam int DP  = 4;
  localparam int PKW = 2*5 + 1 + PW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [4:0] self_id = '0;
  logic loc_in_valid = 0, xin_valid = 0, yin_valid = 0;
  logic [PKW-1:0] loc_in_data = '0, xin_data = '0, yin_data = '0;
  logic loc_in_ready, xin_ready, yin_ready;
  logic loc_out_valid, xout_valid, yout_valid;
  logic loc_out_ready = 1, xout_ready = 1, yout_ready = 1;
  logic [PKW-1:0] loc_out_data, xout_data, yout_data;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;   // 250 MHz

  ring_dor_router #(.PAYLOAD_W(PW), .DEPTH(DP)) dut_i (
    .clk(clk), .rst(rst), .self_id(self_id),
    .loc_in_valid(loc_in_valid), .loc_in_ready(loc_in_ready), .loc_in_data(loc_in_data),
    .xin_valid(xin_valid), .xin_ready(xin_ready), .xin_data(xin_data),
    .yin_valid(yin_valid), .yin_ready(yin_ready), .yin_data(yin_data),
    .loc_out_valid(loc_out_valid), .loc_out_ready(loc_out_ready), .loc_out_data(loc_out_data),
    .xout_valid(xout_valid), .xout_ready(xout_ready), .xout_data(xout_data),
    .yout_valid(yout_valid), .yout_ready(yout_ready), .yout_data(yout_data)
  );

  // vector: {self[13:9], in_port[8:7], dst[6:2], exp_port[1:0]}; ports 0 local, 1 X, 2 Y
  localparam int NV = 13;
  localparam logic [13:0] VEC [NV] = '{
    {5'd0, 2'd0, 5'd9, 2'd1},  // 0->9 hop 1: leave on X
    {5'd8, 2'd1, 5'd9, 2'd2},  // hop 2 at 8: turn to Y
    {5'd9, 2'd2, 5'd9, 2'd0},  // hop 3 at 9: deliver
    {5'd9, 2'd0, 5'd0, 2'd1},  // reply 9->0 hop 1: X
    {5'd1, 2'd1, 5'd0, 2'd2},  // reply at 1: turn Y
    {5'd0, 2'd2, 5'd0, 2'd0},  // reply at 0: deliver
    {5'd0, 2'd0, 5'd1, 2'd2},  // 0->1 on Y only
    {5'd1, 2'd2, 5'd1, 2'd0},
    {5'd1, 2'd0, 5'd8, 2'd1},  // 1->8 X first
    {5'd9, 2'd1, 5'd8, 2'd2},
    {5'd0, 2'd0, 5'd8, 2'd1},  // 1-D ring 0->4->8: no Y hop
    {5'd4, 2'd1, 5'd8, 2'd1},  // pass through
    {5'd3, 2'd0, 5'd3, 2'd0}   // loopback to self
  };

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic set_in(input int p, input logic v, input logic [PKW-1:0] d);
    case (p)
      0: begin loc_in_valid = v; loc_in_data = d; end
      1: begin xin_valid = v; xin_data = d; end
      default: begin yin_valid = v; yin_data = d; end
    endcase
  endtask

  function automatic logic out_v(input int p);
    return (p == 0) ? loc_out_valid : (p == 1) ? xout_valid : yout_valid;
  endfunction

  function automatic logic [PKW-1:0] out_d(input int p);
    return (p == 0) ? loc_out_data : (p == 1) ? xout_data : yout_data;
  endfunction

  function automatic logic [PKW-1:0] mk(input logic [4:0] s, input logic [4:0] d,
                                         input logic r, input logic [PW-1:0] pl);
    return {s, d, r, pl};
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [PKW-1:0] pa, pb;
    int acc, seen;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk({loc_in_ready, xin_ready, yin_ready} == 3'b111, "R1 ready", {loc_in_ready, xin_ready, yin_ready}, 3'b111);
    chk({loc_out_valid, xout_valid, yout_valid} == 3'b000, "R1 valid", {loc_out_valid, xout_valid, yout_valid}, 0);

    // table walk: R2 R3 R4 R5
    for (int v = 0; v < NV; v++) begin
      int ip, ep;
      logic [PKW-1:0] pk;
      ip = int'(VEC[v][8:7]);
      ep = int'(VEC[v][1:0]);
      pk = mk(5'd21, VEC[v][6:2], v[0], PW'(16'hA000 + v));
      self_id = VEC[v][13:9];
      set_in(ip, 1'b1, pk);
      @(posedge clk); @(negedge clk);
      set_in(ip, 1'b0, '0);
      @(posedge clk); @(negedge clk);
      for (int p = 0; p < 3; p++) begin
        if (p == ep) begin
          chk(out_v(p) && out_d(p) == pk,
              (ep == 1) ? "R2 route X/R5" : (ep == 2) ? "R3 route Y/R5" : "R4 route local/R5",
              {out_v(p), out_d(p)}, {1'b1, pk});
        end else begin
          chk(!out_v(p), "R2 R3 R4 no stray output", out_v(p), 0);
        end
      end
      @(negedge clk);
    end

    // R6: X ring input beats local injection for the X output
    self_id = 5'd0;
    pa = mk(5'd4, 5'd8, 1'b0, 16'h1111);
    pb = mk(5'd0, 5'd8, 1'b0, 16'h2222);
    set_in(1, 1'b1, pa);
    set_in(0, 1'b1, pb);
    @(posedge clk); @(negedge clk);
    set_in(1, 1'b0, '0);
    set_in(0, 1'b0, '0);
    @(posedge clk); @(negedge clk);
    chk(xout_valid && xout_data == pa, "R6 ring first", xout_data, pa);
    @(posedge clk); @(negedge clk);
    chk(xout_valid && xout_data == pb, "R6 local second", xout_data, pb);
    @(negedge clk);

    // R7: hold under backpressure
    xout_ready = 0;
    pa = mk(5'd0, 5'd8, 1'b1, 16'h3333);
    set_in(0, 1'b1, pa);
    @(posedge clk); @(negedge clk);
    set_in(0, 1'b0, '0);
    repeat (4) @(negedge clk);
    chk(xout_valid && xout_data == pa, "R7 held", xout_data, pa);
    xout_ready = 1;
    @(negedge clk);
    chk(!xout_valid, "R7 drained", xout_valid, 0);

    // R8: fill toward stalled output
    xout_ready = 0;
    acc = 0;
    for (int c = 0; c < 10; c++) begin
      set_in(0, 1'b1, mk(5'd0, 5'd8, 1'b0, PW'(acc)));
      if (loc_in_ready) acc++;
      @(negedge clk);
    end
    set_in(0, 1'b0, '0);
    chk(acc == DP + 1, "R8 accepted count", acc, DP + 1);
    chk(!loc_in_ready, "R8 ready low when full", loc_in_ready, 0);

    // R9: drain in order
    xout_ready = 1;
    seen = 0;
    for (int c = 0; c < 12; c++) begin
      if (xout_valid) begin
        chk(xout_data[PW-1:0] == PW'(seen), "R9 order", xout_data[PW-1:0], seen);
        seen++;
      end
      @(negedge clk);
    end
    chk(seen == DP + 1, "R8 R9 none lost", seen, DP + 1);

    finish_run();
  end
endmodule